// File: doc/BRIEF.md
# Packet Header Error-Correction Codec

This block protects the 24-bit header of a serial display-link packet with one check byte. The header is the identifier byte (channel number and packet kind) followed by two bytes of short-packet data or a length field. The encoder side turns 24 header bits into the check byte, using a fixed six-parity Hamming code. The two top bits of that byte are always zero.

The decoder side takes a received header and check byte. It recomputes the parity and forms the syndrome, which is the received byte XOR the recomputed one. From the syndrome it repairs any single flipped bit, whether that bit is in the header or in the check byte. It flags any pattern of two flipped bits as beyond repair. The repaired header is returned together with its channel and packet-kind fields.

With the parameter `REG_OUT` set to 1 (the default), the decoder results pass through one register stage. With `REG_OUT` set to 0, the decoder is purely combinational. The encoder is always combinational.

Top module: `hdr_ecc_codec`

## Requirements
- R1: `enc_ecc[7:6]` is always 00. Each bit `enc_ecc[k]` is the XOR of the header bits listed here, where bit 0 is the LSB of the identifier byte:
  - k=0: 0,1,2,4,5,7,10,11,13,16,20,21,22,23
  - k=1: 0,1,3,4,6,8,10,12,14,17,20,21,22,23
  - k=2: 0,2,3,5,6,9,11,12,15,18,20,21,22
  - k=3: 1,2,3,7,8,9,13,14,15,19,20,21,23
  - k=4: 4..9, 16..20, 22, 23
  - k=5: 10..19, 21, 22, 23
- R2: When the received check byte equals the check byte of the received header, `out_hdr` equals the received header, and both `out_corrected` and `out_uncorr` are low.
- R3: When exactly one header bit is flipped, `out_hdr` is the original header, `out_corrected` is high and `out_uncorr` is low.
- R4: When exactly one check-byte bit (any of the 8) is flipped, `out_hdr` equals the received header, `out_corrected` is high and `out_uncorr` is low.
- R5: When any two bits of the 32 received bits are flipped, `out_uncorr` is high and `out_corrected` is low. `out_hdr` equals the received header unchanged.
- R6: `out_vc` equals `out_hdr[7:6]` and `out_dt` equals `out_hdr[5:0]`.
- R7: With `REG_OUT`=1, `out_vld` and all decoder results appear one clock after `dec_in_vld` is sampled high. Reset (active-low `rst_n`) clears `out_vld`, `out_corrected` and `out_uncorr`. The flags are low whenever `out_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_hdr | input | 24 | Header to encode |
| enc_ecc | output | 8 | Check byte for `enc_hdr` |
| dec_in_vld | input | 1 | Received header and check byte are valid |
| dec_hdr | input | 24 | Received header |
| dec_ecc | input | 8 | Received check byte |
| out_vld | output | 1 | Decoder results are valid |
| out_hdr | output | 24 | Repaired header |
| out_vc | output | 2 | Channel number from the repaired header |
| out_dt | output | 6 | Packet kind from the repaired header |
| out_corrected | output | 1 | One bit was repaired |
| out_uncorr | output | 1 | Error beyond repair detected |

## Verification
Several properties are checked by assertions on every cycle:
- the repair mask never has more than one bit set;
- a zero syndrome never raises a flag;
- a case beyond repair never changes the header;
- the two flags are never high together;
- the output valid tracks the input valid one cycle later.

Only the bench scenarios can show that the parity equations are the right ones. The same holds for mapping each of the 24 single-bit flips back to its original header, repairing a flip in the check byte without touching the header, and catching the mixed double flips (header–header, header–check, check–check). The bench shows these by comparing against its own bit-by-bit parity model.

// File: rtl/hdr_ecc_pkg.sv
package hdr_ecc_pkg;
  localparam int HDR_W = 24;
  localparam int ECC_W = 8;
  localparam int PAR_W = 6;

  typedef logic [HDR_W-1:0] hdr_t;
  typedef logic [ECC_W-1:0] ecc_t;

  typedef enum logic [1:0] {
    SYN_CLEAN    = 2'd0,
    SYN_ECC_BIT  = 2'd1,
    SYN_DATA_BIT = 2'd2,
    SYN_UNCORR   = 2'd3
  } syn_kind_e;

  // Header bits covered by each parity bit.
  function automatic hdr_t par_cover(input int k);
    case (k)
      0:       par_cover = 24'hF12CB7;
      1:       par_cover = 24'hF2555B;
      2:       par_cover = 24'h749A6D;
      3:       par_cover = 24'hB8E38E;
      4:       par_cover = 24'hDF03F0;
      5:       par_cover = 24'hEFFC00;
      default: par_cover = '0;
    endcase
  endfunction

  function automatic ecc_t ecc_of(input hdr_t h);
    ecc_t r;
    r = '0;
    for (int k = 0; k < PAR_W; k++) r[k] = ^(h & par_cover(k));
    return r;
  endfunction

  // Syndrome produced by a flip of header bit i.
  function automatic ecc_t column_of(input int i);
    return ecc_of(hdr_t'(1) << i);
  endfunction
endpackage

// File: rtl/hdr_ecc_gen.sv
module hdr_ecc_gen
  import hdr_ecc_pkg::*;
(
  input  hdr_t hdr,
  output ecc_t ecc
);
  always_comb ecc = ecc_of(hdr);
endmodule

// File: rtl/hdr_ecc_locate.sv
module hdr_ecc_locate
  import hdr_ecc_pkg::*;
(
  input  ecc_t      syndrome,
  output hdr_t      flip_mask,
  output syn_kind_e kind
);
  hdr_t col_hit;

  genvar gi;
  generate
    for (gi = 0; gi < HDR_W; gi++) begin : g_col
      assign col_hit[gi] = (syndrome == column_of(gi));
    end
  endgenerate

  logic single_ecc;
  assign single_ecc = ($countones(syndrome) == 1);

  always_comb begin
    flip_mask = '0;
    if (syndrome == '0)   kind = SYN_CLEAN;
    else if (single_ecc)  kind = SYN_ECC_BIT;
    else if (|col_hit) begin
      kind      = SYN_DATA_BIT;
      flip_mask = col_hit;
    end
    else                  kind = SYN_UNCORR;
  end
endmodule

// File: rtl/hdr_ecc_codec.sv
module hdr_ecc_codec
  import hdr_ecc_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [23:0] enc_hdr,
  output logic [7:0]  enc_ecc,
  input  logic        dec_in_vld,
  input  logic [23:0] dec_hdr,
  input  logic [7:0]  dec_ecc,
  output logic        out_vld,
  output logic [23:0] out_hdr,
  output logic [1:0]  out_vc,
  output logic [5:0]  out_dt,
  output logic        out_corrected,
  output logic        out_uncorr
);
  // Encoder
  hdr_ecc_gen u_enc (.hdr(enc_hdr), .ecc(enc_ecc));

  // Decoder
  ecc_t      recalc;
  ecc_t      syndrome;
  hdr_t      flip_mask;
  syn_kind_e kind;
  hdr_t      fixed_hdr;
  logic      fix_corr;
  logic      fix_uncorr;

  hdr_ecc_gen u_chk (.hdr(dec_hdr), .ecc(recalc));
  assign syndrome = dec_ecc ^ recalc;

  hdr_ecc_locate u_loc (.syndrome(syndrome), .flip_mask(flip_mask), .kind(kind));

  assign fixed_hdr  = dec_hdr ^ flip_mask;
  assign fix_corr   = dec_in_vld && (kind == SYN_ECC_BIT || kind == SYN_DATA_BIT);
  assign fix_uncorr = dec_in_vld && (kind == SYN_UNCORR);

  generate
    if (REG_OUT) begin : g_reg
      hdr_t hdr_q;
      logic vld_q, corr_q, unc_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q  <= 1'b0;
          corr_q <= 1'b0;
          unc_q  <= 1'b0;
          hdr_q  <= '0;
        end else begin
          vld_q  <= dec_in_vld;
          corr_q <= fix_corr;
          unc_q  <= fix_uncorr;
          if (dec_in_vld) hdr_q <= fixed_hdr;
        end
      end
      assign out_vld       = vld_q;
      assign out_hdr       = hdr_q;
      assign out_corrected = corr_q;
      assign out_uncorr    = unc_q;

      // R7: valid follows input valid after one clock
      a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        dec_in_vld |=> out_vld);
      a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_in_vld |=> !out_vld && !out_corrected && !out_uncorr);
    end else begin : g_comb
      assign out_vld       = dec_in_vld;
      assign out_hdr       = fixed_hdr;
      assign out_corrected = fix_corr;
      assign out_uncorr    = fix_uncorr;
    end
  endgenerate

  assign out_vc = out_hdr[7:6];
  assign out_dt = out_hdr[5:0];

  // R3: at most one header bit is ever repaired
  always_comb begin
    a_r3_single_flip: assert ($countones(flip_mask) <= 1);
  end
  // R2: zero syndrome leaves header and flags untouched
  always_comb begin
    if (syndrome == '0)
      a_r2_clean_quiet: assert (flip_mask == '0 && kind == SYN_CLEAN);
  end
  // R5: a case beyond repair never alters the header
  always_comb begin
    if (kind == SYN_UNCORR)
      a_r5_uncorr_no_flip: assert (flip_mask == '0);
  end
  // R5: flags are mutually exclusive at the outputs
  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_corrected && out_uncorr));
endmodule

// File: tb/hdr_ecc_codec_bench.sv
module hdr_ecc_codec_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] enc_hdr = '0;
  logic [7:0]  enc_ecc;
  logic        dec_in_vld = 1'b0;
  logic [23:0] dec_hdr = '0;
  logic [7:0]  dec_ecc = '0;
  logic        out_vld;
  logic [23:0] out_hdr;
  logic [1:0]  out_vc;
  logic [5:0]  out_dt;
  logic        out_corrected;
  logic        out_uncorr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hdr_ecc_codec u_hdr_ecc_codec (
    .clk(clk), .rst_n(rst_n), .enc_hdr(enc_hdr), .enc_ecc(enc_ecc),
    .dec_in_vld(dec_in_vld), .dec_hdr(dec_hdr), .dec_ecc(dec_ecc),
    .out_vld(out_vld), .out_hdr(out_hdr), .out_vc(out_vc), .out_dt(out_dt),
    .out_corrected(out_corrected), .out_uncorr(out_uncorr));

  typedef struct {
    logic [23:0] hdr;
    logic        corr;
    logic        unc;
    string       req;
  } exp_t;
  exp_t sb[$];

  function automatic logic [7:0] ref_ecc(input logic [23:0] h);
    logic [7:0] p;
    p[7] = 1'b0;
    p[6] = 1'b0;
    p[5] = h[10]^h[11]^h[12]^h[13]^h[14]^h[15]^h[16]^h[17]^h[18]^h[19]^h[21]^h[22]^h[23];
    p[4] = h[4]^h[5]^h[6]^h[7]^h[8]^h[9]^h[16]^h[17]^h[18]^h[19]^h[20]^h[22]^h[23];
    p[3] = h[1]^h[2]^h[3]^h[7]^h[8]^h[9]^h[13]^h[14]^h[15]^h[19]^h[20]^h[21]^h[23];
    p[2] = h[0]^h[2]^h[3]^h[5]^h[6]^h[9]^h[11]^h[12]^h[15]^h[18]^h[20]^h[21]^h[22];
    p[1] = h[0]^h[1]^h[3]^h[4]^h[6]^h[8]^h[10]^h[12]^h[14]^h[17]^h[20]^h[21]^h[22]^h[23];
    p[0] = h[0]^h[1]^h[2]^h[4]^h[5]^h[7]^h[10]^h[11]^h[13]^h[16]^h[20]^h[21]^h[22]^h[23];
    return p;
  endfunction

  task automatic check(input string req, input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // R1: encoder check
  task automatic enc_check(input logic [23:0] h);
    @(negedge clk);
    enc_hdr = h;
    #1;
    check("R1", enc_ecc == ref_ecc(h), "enc_ecc", {24'h0, enc_ecc}, {24'h0, ref_ecc(h)});
  endtask

  // Driver: one received word per cycle, expectation pushed to scoreboard
  task automatic drive(input logic [23:0] h, input logic [7:0] e, input exp_t x);
    @(negedge clk);
    dec_in_vld = 1'b1;
    dec_hdr    = h;
    dec_ecc    = e;
    sb.push_back(x);
  endtask

  task automatic idle();
    @(negedge clk);
    dec_in_vld = 1'b0;
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_vld) begin
        if (sb.size() == 0) begin
          check("R7", 1'b0, "unexpected out_vld", 32'd1, 32'd0);
        end else begin
          exp_t x;
          x = sb.pop_front();
          check(x.req, out_hdr == x.hdr, "out_hdr", {8'h0, out_hdr}, {8'h0, x.hdr});
          check(x.req, out_corrected == x.corr, "out_corrected",
                {31'h0, out_corrected}, {31'h0, x.corr});
          check(x.req, out_uncorr == x.unc, "out_uncorr",
                {31'h0, out_uncorr}, {31'h0, x.unc});
          check("R6", out_vc == x.hdr[7:6] && out_dt == x.hdr[5:0], "vc/dt",
                {24'h0, out_vc, out_dt}, {24'h0, x.hdr[7:0]});
        end
      end else begin
        check("R7", !out_corrected && !out_uncorr, "flags while idle",
              {30'h0, out_corrected, out_uncorr}, 32'h0);
      end
    end
  end

  // Watchdog
  initial begin
    #(8 * 50000);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  logic [23:0] hdrs [4] = '{24'h000000, 24'h12_34_3E, 24'hFF_FF_FF, 24'hA5_0F_C9};

  initial begin
    exp_t x;
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7", out_vld == 1'b0 && !out_corrected && !out_uncorr, "reset outputs",
          {29'h0, out_vld, out_corrected, out_uncorr}, 32'h0);
    rst_n = 1'b1;

    // R1: encoder over several patterns and every single bit
    foreach (hdrs[i]) enc_check(hdrs[i]);
    for (int b = 0; b < 24; b++) enc_check(24'h1 << b);

    foreach (hdrs[i]) begin
      logic [23:0] h;
      logic [7:0]  e;
      h = hdrs[i];
      e = ref_ecc(h);
      // R2: clean word
      x = '{hdr: h, corr: 1'b0, unc: 1'b0, req: "R2"};
      drive(h, e, x);
      // R3: each header bit flipped
      for (int b = 0; b < 24; b++) begin
        x = '{hdr: h, corr: 1'b1, unc: 1'b0, req: "R3"};
        drive(h ^ (24'h1 << b), e, x);
      end
      // R4: each check-byte bit flipped, including the two fixed-zero bits
      for (int b = 0; b < 8; b++) begin
        x = '{hdr: h, corr: 1'b1, unc: 1'b0, req: "R4"};
        drive(h, e ^ (8'h1 << b), x);
      end
      // R5: header-header, header-check and check-check double flips
      for (int b = 0; b < 23; b++) begin
        x = '{hdr: h ^ (24'h3 << b), corr: 1'b0, unc: 1'b1, req: "R5"};
        drive(h ^ (24'h3 << b), e, x);
      end
      for (int b = 0; b < 8; b++) begin
        x = '{hdr: h ^ (24'h1 << (3 * b)), corr: 1'b0, unc: 1'b1, req: "R5"};
        drive(h ^ (24'h1 << (3 * b)), e ^ (8'h1 << b), x);
      end
      for (int b = 0; b < 7; b++) begin
        x = '{hdr: h, corr: 1'b0, unc: 1'b1, req: "R5"};
        drive(h, e ^ (8'h3 << b), x);
      end
      idle();
      idle();
    end

    // R7: back-to-back then gap
    x = '{hdr: 24'h00_02_C1, corr: 1'b0, unc: 1'b0, req: "R7"};
    drive(24'h00_02_C1, ref_ecc(24'h00_02_C1), x);
    idle();
    repeat (3) @(negedge clk);
    check("R7", sb.size() == 0, "scoreboard drained", sb.size(), 32'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule